// File: doc/BRIEF.md
# Three-Mode 32-Bit Timer With Shared Pin

This block is a general-purpose timer built around one counter that serves three jobs, chosen by a mode field. In waveform mode it drives its pin with a repeating pulse of programmable period and high time. In capture mode it measures an incoming signal, recording how long the pin stays high and how long a full rise-to-rise cycle lasts. In watchdog mode it counts idle cycles and flags an expiry when no rising edge arrives on the pin within a programmed limit. The pin drives in waveform mode only. In the other modes it is an input, and the incoming level passes through a two-stage synchroniser before any edge is detected.

The mode, period, high time and enable arrive as plain configuration inputs. The captured values, the live count and four sticky event flags are presented as outputs. The flags are cleared by a write-one-to-clear strobe, and an interrupt line is the OR of the three event flags.

The controller has six named states. ST_IDLE is left on enable into ST_WAVE, ST_CAP_ARM or ST_WD_RUN, depending on the mode. Every other state returns to ST_IDLE when the enable drops. ST_CAP_ARM moves to ST_CAP_RUN on a rising edge. ST_CAP_RUN loops on itself at each rising edge, which commits the capture and restarts the count, and falls back to ST_CAP_ARM when the counter overflows. ST_WD_RUN moves to ST_WD_EXPIRED when the count reaches the limit. ST_WD_EXPIRED returns to ST_WD_RUN on a rising edge.

Top module: `gpt_timer`

## Requirements
- R1: When `cfg_en` is low the block is idle one clock later: count 0, `pin_oe` 0 and `pin_o` 0. The mode is sampled only when the block leaves idle, so later changes to `cfg_mode` while it runs have no effect. Mode encoding: 0 waveform, 1 capture, 2 watchdog, 3 reserved. Enabling with mode 3 leaves the block idle with the count at 0.
- R2: In waveform mode the count is 1 on the first clock edge after enable. It then steps by one each cycle up to the period value and returns to 1 on the next edge. A period of 0 behaves as a period of 1.
- R3: In waveform mode `pin_oe` is 1, and `pin_o` is 1 exactly in those cycles where the count is less than or equal to `cfg_width`. A width of 0 keeps the pin low, and a width at or above the period keeps it high.
- R4: In waveform mode, flag bit 0 becomes set one clock after a cycle in which the count equals the period.
- R5: In capture mode a first rising edge arms the measurement. Each later rising edge loads the pulse-width output with the number of cycles the pin was high and the period output with the number of cycles since the previous rising edge. It also sets flag bit 1, and the count becomes 1 on the third clock edge after the pin change.
- R6: In capture mode, if the count reaches all ones without a rising edge, flag bit 3 is set, the measurement in progress is discarded and the block re-arms with count 0. Both captured outputs keep their old values, and bit 3 does not raise the interrupt.
- R7: In watchdog mode the count starts at 0 and a rising edge on the pin resets it to 0. If the count reaches the period value first, flag bit 2 is set and the count freezes at that value until the next rising edge restarts it from 0.
- R8: Flags are sticky across disable. A 1 in `sts_clr` clears the matching flag on the next edge, and a new event in the same cycle wins over the clear. `irq` is high whenever flag bit 0, 1 or 2 is set.
- R9: `pin_oe` is 0 in capture, watchdog and idle states, so the pin is only an input there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Timer enable |
| cfg_mode | input | 2 | Operating mode (0 waveform, 1 capture, 2 watchdog, 3 reserved) |
| cfg_period | input | CNT_W | Waveform period / watchdog limit in cycles |
| cfg_width | input | CNT_W | Waveform high time in cycles |
| sts_clr | input | 4 | Write-one-to-clear strobe per flag |
| pin_i | input | 1 | Pin level as seen from outside |
| pin_o | output | 1 | Pin level driven in waveform mode |
| pin_oe | output | 1 | Pin output enable |
| count_o | output | CNT_W | Live counter value |
| cap_width_o | output | CNT_W | Last committed pulse width |
| cap_period_o | output | CNT_W | Last committed period |
| sts_flags_o | output | 4 | Flags: bit0 period, bit1 capture, bit2 expiry, bit3 overflow |
| irq | output | 1 | Interrupt request |

## Verification
Waveform results follow a configuration change after one clock edge: the count and the pin it drives appear together, and any flag appears one edge after the cycle whose count triggers it. A pin edge takes effect on the third rising clock edge after it is applied, because of the two synchroniser stages and the edge-detect register. The captured values and the restarted count are therefore checked five edges after the final rise, and watchdog recovery is checked four edges after an edge. The bench drives inputs and samples outputs on falling clock edges, and it predicts each cycle's count, pin level and flags from the cycle index since enable.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    typedef enum logic [1:0] {
        MODE_WAVE = 2'd0,
        MODE_CAPT = 2'd1,
        MODE_WDOG = 2'd2,
        MODE_RSVD = 2'd3
    } gpt_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_WAVE       = 3'd1,
        ST_CAP_ARM    = 3'd2,
        ST_CAP_RUN    = 3'd3,
        ST_WD_RUN     = 3'd4,
        ST_WD_EXPIRED = 3'd5
    } gpt_state_e;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_ZERO = 2'd1,
        CNT_ONE  = 2'd2,
        CNT_INC  = 2'd3
    } cnt_op_e;

    localparam int NUM_FLAGS  = 4;
    localparam int FLG_PERIOD = 0;
    localparam int FLG_CAPT   = 1;
    localparam int FLG_EXPIRE = 2;
    localparam int FLG_OVF    = 3;
    localparam logic [NUM_FLAGS-1:0] FLG_IRQ_MASK = 4'b0111;

endpackage

// File: rtl/gpt_edge_sync.sv
module gpt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        if (STAGES > 1) begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= '0;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], pin_i};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= '0;
                end else begin
                    chain_q <= pin_i;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else begin
            last_q <= chain_q[STAGES-1];
        end
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;
    assign fall_o = ~chain_q[STAGES-1] & last_q;

endmodule

// File: rtl/gpt_count_path.sv
module gpt_count_path
    import gpt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_op_e          cnt_op_i,
    input  logic             latch_pend_i,
    input  logic             commit_i,
    output logic [CNT_W-1:0] count_o,
    output logic             at_max_o,
    output logic [CNT_W-1:0] cap_width_o,
    output logic [CNT_W-1:0] cap_period_o
);

    localparam logic [CNT_W-1:0] CNT_ONE_V = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] pend_q;
    logic [CNT_W-1:0] cap_width_q;
    logic [CNT_W-1:0] cap_period_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            unique case (cnt_op_i)
                CNT_HOLD: count_q <= count_q;
                CNT_ZERO: count_q <= '0;
                CNT_ONE:  count_q <= CNT_ONE_V;
                CNT_INC:  count_q <= count_q + CNT_ONE_V;
                default:  count_q <= count_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q       <= '0;
            cap_width_q  <= '0;
            cap_period_q <= '0;
        end else begin
            if (latch_pend_i) begin
                pend_q <= count_q;
            end
            if (commit_i) begin
                cap_width_q  <= pend_q;
                cap_period_q <= count_q;
            end
        end
    end

    assign count_o      = count_q;
    assign at_max_o     = &count_q;
    assign cap_width_o  = cap_width_q;
    assign cap_period_o = cap_period_q;

    // R6: captured values move only on a commit
    p_cap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> ($stable(cap_width_q) && $stable(cap_period_q)));

    // R5: a commit restarts the measurement at one
    p_restart_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> (count_q == CNT_ONE_V));

endmodule

// File: rtl/gpt_fsm.sv
module gpt_fsm
    import gpt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  gpt_mode_e            mode_i,
    input  logic [CNT_W-1:0]     period_i,
    input  logic [CNT_W-1:0]     width_i,
    input  logic [CNT_W-1:0]     count_i,
    input  logic                 at_max_i,
    input  logic                 rise_i,
    input  logic                 fall_i,
    output cnt_op_e              cnt_op_o,
    output logic                 latch_pend_o,
    output logic                 commit_o,
    output logic [NUM_FLAGS-1:0] ev_o,
    output logic                 pin_o,
    output logic                 pin_oe_o
);

    localparam logic [CNT_W-1:0] CNT_ONE_V = {{(CNT_W-1){1'b0}}, 1'b1};

    gpt_state_e       state_q;
    gpt_state_e       state_d;
    logic [CNT_W-1:0] period_eff;
    logic             wave_wrap;
    logic             wd_limit;

    assign period_eff = (period_i == '0) ? CNT_ONE_V : period_i;
    assign wave_wrap  = (count_i >= period_eff);
    assign wd_limit   = (count_i >= period_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    unique case (mode_i)
                        MODE_WAVE: state_d = ST_WAVE;
                        MODE_CAPT: state_d = ST_CAP_ARM;
                        MODE_WDOG: state_d = ST_WD_RUN;
                        default:   state_d = ST_IDLE;
                    endcase
                end
                ST_WAVE:       state_d = ST_WAVE;
                ST_CAP_ARM:    if (rise_i) state_d = ST_CAP_RUN;
                ST_CAP_RUN:    if (!rise_i && at_max_i) state_d = ST_CAP_ARM;
                ST_WD_RUN:     if (!rise_i && wd_limit) state_d = ST_WD_EXPIRED;
                ST_WD_EXPIRED: if (rise_i) state_d = ST_WD_RUN;
                default:       state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cnt_op_o     = CNT_HOLD;
        latch_pend_o = 1'b0;
        commit_o     = 1'b0;
        ev_o         = '0;
        pin_o        = 1'b0;
        pin_oe_o     = 1'b0;
        if (!en_i) begin
            cnt_op_o = CNT_ZERO;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_op_o = (mode_i == MODE_WAVE) ? CNT_ONE : CNT_ZERO;
                end
                ST_WAVE: begin
                    pin_oe_o = 1'b1;
                    pin_o    = (count_i <= width_i);
                    if (wave_wrap) begin
                        cnt_op_o         = CNT_ONE;
                        ev_o[FLG_PERIOD] = 1'b1;
                    end else begin
                        cnt_op_o = CNT_INC;
                    end
                end
                ST_CAP_ARM: begin
                    cnt_op_o = rise_i ? CNT_ONE : CNT_ZERO;
                end
                ST_CAP_RUN: begin
                    latch_pend_o = fall_i;
                    if (rise_i) begin
                        cnt_op_o       = CNT_ONE;
                        commit_o       = 1'b1;
                        ev_o[FLG_CAPT] = 1'b1;
                    end else if (at_max_i) begin
                        cnt_op_o      = CNT_ZERO;
                        ev_o[FLG_OVF] = 1'b1;
                    end else begin
                        cnt_op_o = CNT_INC;
                    end
                end
                ST_WD_RUN: begin
                    if (rise_i) begin
                        cnt_op_o = CNT_ZERO;
                    end else if (wd_limit) begin
                        cnt_op_o         = CNT_HOLD;
                        ev_o[FLG_EXPIRE] = 1'b1;
                    end else begin
                        cnt_op_o = CNT_INC;
                    end
                end
                ST_WD_EXPIRED: begin
                    cnt_op_o = rise_i ? CNT_ZERO : CNT_HOLD;
                end
                default: cnt_op_o = CNT_ZERO;
            endcase
        end
    end

    // R1: dropping the enable forces idle on the next edge
    p_disable_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (state_q == ST_IDLE));

    // R2: waveform counting never sits at zero
    p_wave_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAVE) |-> (count_i != '0));

    // R7: an expired watchdog holds its count until an edge
    p_wd_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WD_EXPIRED && !rise_i && en_i) |=> $stable(count_i));

endmodule

// File: rtl/gpt_status.sv
module gpt_status
    import gpt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] ev_i,
    input  logic [NUM_FLAGS-1:0] clr_i,
    output logic [NUM_FLAGS-1:0] flags_o,
    output logic                 irq_o
);

    logic [NUM_FLAGS-1:0] flags_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_i) | ev_i;
        end
    end

    assign flags_o = flags_q;
    assign irq_o   = |(flags_q & FLG_IRQ_MASK);

    generate
        for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag_chk
            // R8: an event always lands, even against a clear
            p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
                ev_i[g] |=> flags_q[g]);
            // R8: a clear without an event empties the flag
            p_flag_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[g] && !ev_i[g]) |=> !flags_q[g]);
        end
    endgenerate

endmodule

// File: rtl/gpt_timer.sv
module gpt_timer
    import gpt_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_en,
    input  logic [1:0]           cfg_mode,
    input  logic [CNT_W-1:0]     cfg_period,
    input  logic [CNT_W-1:0]     cfg_width,
    input  logic [NUM_FLAGS-1:0] sts_clr,
    input  logic                 pin_i,
    output logic                 pin_o,
    output logic                 pin_oe,
    output logic [CNT_W-1:0]     count_o,
    output logic [CNT_W-1:0]     cap_width_o,
    output logic [CNT_W-1:0]     cap_period_o,
    output logic [NUM_FLAGS-1:0] sts_flags_o,
    output logic                 irq
);

    logic                 rise;
    logic                 fall;
    cnt_op_e              cnt_op;
    logic                 latch_pend;
    logic                 commit;
    logic                 at_max;
    logic [NUM_FLAGS-1:0] ev;

    gpt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    gpt_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (cfg_en),
        .mode_i       (gpt_mode_e'(cfg_mode)),
        .period_i     (cfg_period),
        .width_i      (cfg_width),
        .count_i      (count_o),
        .at_max_i     (at_max),
        .rise_i       (rise),
        .fall_i       (fall),
        .cnt_op_o     (cnt_op),
        .latch_pend_o (latch_pend),
        .commit_o     (commit),
        .ev_o         (ev),
        .pin_o        (pin_o),
        .pin_oe_o     (pin_oe)
    );

    gpt_count_path #(.CNT_W(CNT_W)) u_count (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnt_op_i     (cnt_op),
        .latch_pend_i (latch_pend),
        .commit_i     (commit),
        .count_o      (count_o),
        .at_max_o     (at_max),
        .cap_width_o  (cap_width_o),
        .cap_period_o (cap_period_o)
    );

    gpt_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_i    (ev),
        .clr_i   (sts_clr),
        .flags_o (sts_flags_o),
        .irq_o   (irq)
    );

    // R9: the pin only starts driving after waveform mode was enabled
    p_oe_wave_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_oe) |-> ($past(cfg_en) && ($past(cfg_mode) == MODE_WAVE)));

endmodule

// File: tb/gpt_timer_test.sv
module gpt_timer_test;

    localparam int CLK_NS = 10;
    localparam int BW     = 10;
    localparam int MAXV   = (1 << BW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_en = 1'b0;
    logic [1:0]    cfg_mode = 2'd0;
    logic [BW-1:0] cfg_period = '0;
    logic [BW-1:0] cfg_width = '0;
    logic [3:0]    sts_clr = '0;
    logic          pin_drv = 1'b0;
    logic          pin_o;
    logic          pin_oe;
    logic [BW-1:0] count_o;
    logic [BW-1:0] cap_width_o;
    logic [BW-1:0] cap_period_o;
    logic [3:0]    sts_flags_o;
    logic          irq;

    int checks = 0;
    int failures = 0;

    always #(CLK_NS/2) clk = ~clk;

    gpt_timer #(.CNT_W(BW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_en       (cfg_en),
        .cfg_mode     (cfg_mode),
        .cfg_period   (cfg_period),
        .cfg_width    (cfg_width),
        .sts_clr      (sts_clr),
        .pin_i        (pin_drv),
        .pin_o        (pin_o),
        .pin_oe       (pin_oe),
        .count_o      (count_o),
        .cap_width_o  (cap_width_o),
        .cap_period_o (cap_period_o),
        .sts_flags_o  (sts_flags_o),
        .irq          (irq)
    );

    function automatic int eff_period(input int p);
        return (p == 0) ? 1 : p;
    endfunction

    function automatic int wave_count(input int k, input int p);
        return (k % eff_period(p)) + 1;
    endfunction

    function automatic int wave_pin(input int cnt, input int w);
        return (cnt <= w) ? 1 : 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiesce();
        @(negedge clk);
        cfg_en  = 1'b0;
        pin_drv = 1'b0;
        sts_clr = 4'hF;
        @(negedge clk);
        sts_clr = 4'h0;
    endtask

    task automatic run_wave(input int p, input int w, input int cycles, input int flip_at);
        quiesce();
        cfg_mode   = 2'd0;
        cfg_period = BW'(p);
        cfg_width  = BW'(w);
        cfg_en     = 1'b1;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (k == flip_at) cfg_mode = 2'd1;
            chk("R2 count", int'(count_o), wave_count(k, p));
            chk("R3 pin", int'(pin_o), wave_pin(wave_count(k, p), w));
            chk("R3 oe", int'(pin_oe), 1);
            chk("R4 flag0", int'(sts_flags_o[0]), (k >= eff_period(p)) ? 1 : 0);
        end
        chk("R8 irq", int'(irq), (cycles > eff_period(p)) ? 1 : 0);
    endtask

    task automatic run_capt(input int h, input int l, input int reps);
        quiesce();
        cfg_mode = 2'd1;
        cfg_en   = 1'b1;
        tick(4);
        for (int r = 0; r < reps; r++) begin
            pin_drv = 1'b1;
            tick(h);
            pin_drv = 1'b0;
            tick(l);
            if (r == 0) chk("R5 no commit before second rise", int'(sts_flags_o[1]), 0);
        end
        pin_drv = 1'b1;
        tick(5);
        chk("R5 width", int'(cap_width_o), h);
        chk("R5 period", int'(cap_period_o), h + l);
        chk("R5 restart count", int'(count_o), 3);
        chk("R5 flag1", int'(sts_flags_o[1]), 1);
        chk("R8 irq capture", int'(irq), 1);
        chk("R9 oe capture", int'(pin_oe), 0);
    endtask

    task automatic run_wdog(input int p, input int gap, input int edges);
        quiesce();
        cfg_mode   = 2'd2;
        cfg_period = BW'(p);
        cfg_en     = 1'b1;
        for (int e = 0; e < edges; e++) begin
            tick(gap);
            pin_drv = 1'b1;
            tick(2);
            pin_drv = 1'b0;
        end
        chk("R7 no expiry while fed", int'(sts_flags_o[2]), 0);
        chk("R9 oe watchdog", int'(pin_oe), 0);
        tick(p + 10);
        chk("R7 expiry flag", int'(sts_flags_o[2]), 1);
        chk("R7 frozen count", int'(count_o), p);
        chk("R8 irq expiry", int'(irq), 1);
        pin_drv = 1'b1;
        tick(4);
        chk("R7 restart after edge", int'(count_o), 1);
        chk("R8 flag sticky", int'(sts_flags_o[2]), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unsigned seed_v;
        int hold_w;
        int hold_p;
        seed_v = $urandom(32'd424242);
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // reset state
        chk("R1 reset count", int'(count_o), 0);
        chk("R9 reset oe", int'(pin_oe), 0);
        chk("R8 reset flags", int'(sts_flags_o), 0);
        chk("R8 reset irq", int'(irq), 0);
        chk("R5 reset width", int'(cap_width_o), 0);

        // directed waveform corners
        run_wave(5, 2, 13, -1);
        run_wave(4, 0, 10, -1);
        run_wave(3, 7, 8, -1);
        run_wave(0, 1, 4, -1);
        // R1: mode change while running is ignored
        run_wave(6, 3, 14, 2);

        // R1: disable returns to idle, flags retained
        @(negedge clk);
        cfg_en = 1'b0;
        @(negedge clk);
        chk("R1 disabled count", int'(count_o), 0);
        chk("R1 disabled oe", int'(pin_oe), 0);
        chk("R1 disabled pin", int'(pin_o), 0);
        chk("R8 flag kept on disable", int'(sts_flags_o[0]), 1);
        sts_clr = 4'h1;
        @(negedge clk);
        sts_clr = 4'h0;
        chk("R8 cleared flag0", int'(sts_flags_o[0]), 0);
        chk("R8 irq after clear", int'(irq), 0);

        // R1: reserved mode stays idle
        cfg_mode = 2'd3;
        cfg_en   = 1'b1;
        tick(5);
        chk("R1 reserved count", int'(count_o), 0);
        chk("R1 reserved oe", int'(pin_oe), 0);

        // random waveforms
        for (int i = 0; i < 6; i++) begin
            int p;
            int w;
            p = 1 + int'($urandom_range(19));
            w = int'($urandom_range(22));
            run_wave(p, w, 3 * p + 2, -1);
        end

        // capture, directed then random
        run_capt(4, 6, 2);
        run_capt(1, 1, 3);
        for (int i = 0; i < 5; i++) begin
            run_capt(1 + int'($urandom_range(29)), 1 + int'($urandom_range(29)), 2);
        end

        // R6: overflow keeps captured values, re-arms, no irq
        hold_w = int'(cap_width_o);
        hold_p = int'(cap_period_o);
        sts_clr = 4'hF;
        @(negedge clk);
        sts_clr = 4'h0;
        tick(MAXV + 80);
        chk("R6 overflow flag", int'(sts_flags_o[3]), 1);
        chk("R6 width kept", int'(cap_width_o), hold_w);
        chk("R6 period kept", int'(cap_period_o), hold_p);
        chk("R6 rearmed count", int'(count_o), 0);
        chk("R6 no irq", int'(irq), 0);

        // watchdog, directed then random
        run_wdog(30, 10, 5);
        for (int i = 0; i < 4; i++) begin
            int p;
            p = 20 + int'($urandom_range(40));
            run_wdog(p, 1 + int'($urandom_range(p - 8)), 3);
        end

        quiesce();
        tick(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule